// File: doc/BRIEF.md
# Register Command List Processor

This block consumes a list of 32-bit words and turns it into writes to a 1024-entry, 32-bit register file. A list is a series of commands. Each command holds a data word and then a header word. The header names a target register, a 4-bit byte-enable mask, a count of additional data words and an addressing flag. The block applies the first data word to the target register. Each additional word is then applied either to the same register or to successive registers. Every write is a byte-masked read-modify-write, so disabled bytes keep their old contents.

Software pulses `start` with the list length in words and then presents the words on a valid/ready stream. Commands always begin on an even word offset from the start of the list. When the reader sits at an odd offset it drops one word before it reads the next command. The list ends when the number of words consumed equals the length. A second read port lets the register contents be inspected. Every register write that is accepted produces a one-cycle event carrying the register index and the value written. A sticky error flag reports bad register indices and truncated commands.

Top module: `cmdlist_proc`

## Requirements
- R1: A command is a data word followed by a header word. The header carries the register index in bits [15:0], the byte-enable mask in bits [19:16], the count of additional data words in bits [27:20] and the consecutive-addressing flag in bit 31. The data word is written to the register named by the index.
- R2: Before a command is read, a position at an odd word offset from the list start causes one word to be consumed and discarded.
- R3: After the first write, the additional data words counted in the header are each written with the header's mask.
- R4: With the addressing flag at 1, additional word i (counting from 0) goes to index+i+1. With the flag at 0, every additional word goes to the same index.
- R5: Mask bit k enables byte k (bits 8k+7..8k). The stored result is (old AND NOT m) OR (data AND m), where m is the expanded mask.
- R6: A write whose index is 1024 or larger changes no register, produces no event and sets the error flag.
- R7: Processing ends when the consumed word count equals `list_len`. `busy` then falls and `in_ready` stays low.
- R8: Each accepted write gives exactly one single-cycle `evt_valid` pulse, with `evt_id` and `evt_data` equal to the register index and its new value.
- R9: If the list ends after a command's data word, or before all of its additional words arrive, the rest of that command is dropped and the error flag is set. Writes already made are kept.
- R10: After reset, `busy`, `err`, `evt_valid` and `in_ready` are 0 and every register reads 0. A `start` accepted while idle clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a list (ignored while busy) |
| list_len | input | LEN_W | List length in words, sampled with start |
| in_valid | input | 1 | List word is present |
| in_data | input | 32 | List word |
| in_ready | output | 1 | Block takes the word this cycle |
| busy | output | 1 | A list is in progress |
| chk_addr | input | AW | Inspection read index |
| chk_data | output | 32 | Register contents, one cycle after chk_addr |
| evt_valid | output | 1 | Register write event |
| evt_id | output | AW | Index written |
| evt_data | output | 32 | Value stored |
| err | output | 1 | Sticky error: bad index or truncated command |

## Verification
The hardest case to reach from the ports is a list that ends part-way through a command burst. The length has to cut off the words after a header has promised more of them, and it has to do so at both the data-word and the additional-word positions. The stimulus covers this with lists whose `list_len` is deliberately shorter than the command stream. The bench then checks that the writes already made survive, that the next register keeps its old value, and that the error flag rises. The skip of an odd-offset word is reached the same way. A repeated-address burst with an odd count leaves the reader at an odd offset, and the filler word that follows carries a value that would be visible in a register if it were wrongly taken as data.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;

  localparam int WORD_W = 32;
  localparam int HID_W  = 16;
  localparam int MASK_W = 4;
  localparam int CNT_W  = 8;

  typedef struct packed {
    logic              seq;
    logic [2:0]        rsv;
    logic [CNT_W-1:0]  more;
    logic [MASK_W-1:0] ben;
    logic [HID_W-1:0]  idx;
  } cmd_hdr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_HDR,
    ST_MORE,
    ST_READ,
    ST_WRITE
  } cl_state_t;

endpackage

// File: rtl/cmdlist_byte_merge.sv
module cmdlist_byte_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int W     = LANES * LANE_W
) (
  input  logic [W-1:0]     old_word,
  input  logic [W-1:0]     new_word,
  input  logic [LANES-1:0] lane_en,
  output logic [W-1:0]     merged
);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged[b*LANE_W +: LANE_W] = lane_en[b] ? new_word[b*LANE_W +: LANE_W]
                                                   : old_word[b*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/cmdlist_regfile.sv
module cmdlist_regfile #(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic          we,
  input  logic [AW-1:0] w_addr,
  input  logic [DW-1:0] w_data,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_q
);

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[w_addr] <= w_data;
    a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end

endmodule

// File: rtl/cmdlist_parser.sv
module cmdlist_parser
  import cmdlist_pkg::*;
#(
  parameter int NREG  = 1024,
  parameter int LEN_W = 16,
  localparam int AW   = $clog2(NREG),
  localparam int TW   = HID_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  list_len,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              busy,
  output logic [AW-1:0]     rd_addr,
  input  logic [WORD_W-1:0] rd_q,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              evt_valid,
  output logic [AW-1:0]     evt_id,
  output logic [WORD_W-1:0] evt_data,
  output logic              err
);

  cl_state_t         state;
  logic [LEN_W-1:0]  pos, len_q;
  logic [WORD_W-1:0] data_q;
  logic [HID_W-1:0]  base_q;
  logic [MASK_W-1:0] ben_q;
  logic              seq_q;
  logic [CNT_W-1:0]  left_q, step_q;
  logic [TW-1:0]     tgt_q;
  logic              at_end, take, tgt_bad;
  cmd_hdr_t          hdr;
  cl_state_t         after_wr;
  logic [WORD_W-1:0] merged;

  assign hdr      = cmd_hdr_t'(in_data);
  assign at_end   = (pos == len_q);
  assign in_ready = ((state == ST_DATA) || (state == ST_HDR) || (state == ST_MORE)) && !at_end;
  assign take     = in_ready && in_valid;
  assign busy     = (state != ST_IDLE);
  assign tgt_bad  = (tgt_q >= TW'(NREG));
  assign after_wr = (left_q != '0) ? ST_MORE : ST_DATA;

  assign rd_addr = tgt_q[AW-1:0];
  assign wr_addr = tgt_q[AW-1:0];
  assign wr_en   = (state == ST_WRITE);
  assign wr_data = merged;

  cmdlist_byte_merge #(.LANES(MASK_W), .LANE_W(WORD_W / MASK_W)) u_merge (
    .old_word (rd_q),
    .new_word (data_q),
    .lane_en  (ben_q),
    .merged   (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pos       <= '0;
      len_q     <= '0;
      data_q    <= '0;
      base_q    <= '0;
      ben_q     <= '0;
      seq_q     <= 1'b0;
      left_q    <= '0;
      step_q    <= '0;
      tgt_q     <= '0;
      err       <= 1'b0;
      evt_valid <= 1'b0;
      evt_id    <= '0;
      evt_data  <= '0;
    end else begin
      evt_valid <= 1'b0;
      if (take) pos <= pos + 1'b1;
      case (state)
        ST_IDLE: begin
          if (start) begin
            len_q <= list_len;
            pos   <= '0;
            err   <= 1'b0;
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (at_end) begin
            state <= ST_IDLE;
          end else if (take && !pos[0]) begin
            data_q <= in_data;
            state  <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (at_end) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else if (take) begin
            base_q <= hdr.idx;
            ben_q  <= hdr.ben;
            seq_q  <= hdr.seq;
            left_q <= hdr.more;
            step_q <= '0;
            tgt_q  <= {1'b0, hdr.idx};
            state  <= ST_READ;
          end
        end
        ST_MORE: begin
          if (at_end) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else if (take) begin
            data_q <= in_data;
            tgt_q  <= seq_q ? TW'(base_q) + TW'(step_q) + TW'(1) : TW'(base_q);
            step_q <= step_q + 1'b1;
            left_q <= left_q - 1'b1;
            state  <= ST_READ;
          end
        end
        ST_READ: begin
          if (tgt_bad) begin
            err   <= 1'b1;
            state <= after_wr;
          end else begin
            state <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          evt_valid <= 1'b1;
          evt_id    <= tgt_q[AW-1:0];
          evt_data  <= merged;
          state     <= after_wr;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmdlist_proc.sv
module cmdlist_proc #(
  parameter int NREG  = 1024,
  parameter int LEN_W = 16,
  localparam int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] list_len,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  output logic             busy,
  input  logic [AW-1:0]    chk_addr,
  output logic [31:0]      chk_data,
  output logic             evt_valid,
  output logic [AW-1:0]    evt_id,
  output logic [31:0]      evt_data,
  output logic             err
);

  logic [AW-1:0] rd_addr, wr_addr;
  logic [31:0]   rd_q, wr_data;
  logic          wr_en;

  cmdlist_parser #(.NREG(NREG), .LEN_W(LEN_W)) u_parser (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .list_len  (list_len),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .busy      (busy),
    .rd_addr   (rd_addr),
    .rd_q      (rd_q),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .evt_valid (evt_valid),
    .evt_id    (evt_id),
    .evt_data  (evt_data),
    .err       (err)
  );

  cmdlist_regfile #(.DEPTH(NREG), .DW(32)) u_regs (
    .clk    (clk),
    .a_addr (rd_addr),
    .a_q    (rd_q),
    .we     (wr_en),
    .w_addr (wr_addr),
    .w_data (wr_data),
    .b_addr (chk_addr),
    .b_q    (chk_data)
  );

endmodule

// File: rtl/cmdlist_proc_chk.sv
module cmdlist_proc_chk #(
  parameter int NREG = 1024,
  localparam int AW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          in_ready,
  input logic          busy,
  input logic          evt_valid,
  input logic [AW-1:0] evt_id,
  input logic          err
);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> !evt_valid);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !evt_valid);

  a_r7_ready_needs_busy: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy);

  a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !err));

  a_r7_end_closes: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !in_ready);

endmodule

bind cmdlist_proc cmdlist_proc_chk #(.NREG(NREG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .in_ready  (in_ready),
  .busy      (busy),
  .evt_valid (evt_valid),
  .evt_id    (evt_id),
  .err       (err)
);

// File: tb/test_cmdlist_proc.sv
module test_cmdlist_proc;

  localparam int NREG = 1024;
  localparam int AW   = 10;

  logic             clk = 0;
  logic             rst = 1;
  logic             start = 0;
  logic [15:0]      list_len = 0;
  logic             in_valid = 0;
  logic [31:0]      in_data = 0;
  logic             in_ready, busy, evt_valid, err;
  logic [AW-1:0]    chk_addr = 0;
  logic [31:0]      chk_data, evt_data;
  logic [AW-1:0]    evt_id;

  int checks = 0;
  int errors = 0;

  logic [31:0] lst [32];
  logic [31:0] ev_dat [32];
  logic [AW-1:0] ev_id [32];
  int ev_n = 0;

  always #2 clk = ~clk;

  cmdlist_proc #(.NREG(NREG), .LEN_W(16)) i_cmdlist_proc (
    .clk(clk), .rst(rst), .start(start), .list_len(list_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .busy(busy),
    .chk_addr(chk_addr), .chk_data(chk_data),
    .evt_valid(evt_valid), .evt_id(evt_id), .evt_data(evt_data), .err(err)
  );

  always @(posedge clk) begin
    if (evt_valid && ev_n < 32) begin
      ev_id[ev_n]  <= evt_id;
      ev_dat[ev_n] <= evt_data;
      ev_n <= ev_n + 1;
    end
  end

  function automatic logic [31:0] mk_hdr(int id, logic [3:0] m, int extra, bit seq);
    return {seq, 3'b000, 8'(extra), m, 16'(id)};
  endfunction

  function automatic logic [31:0] mix(logic [31:0] o, logic [31:0] n, logic [3:0] m);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = m[k] ? n[8*k +: 8] : o[8*k +: 8];
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(int n, int len);
    @(negedge clk);
    ev_n = 0;
    start = 1; list_len = 16'(len);
    @(negedge clk);
    start = 0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = lst[i];
      while (!in_ready && busy) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0;
    for (int t = 0; t < 200 && busy; t++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk);
    chk_addr = AW'(a);
    @(negedge clk);
    v = chk_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check(!busy && !err && !evt_valid && !in_ready, "R10 reset outputs",
          {busy, err, evt_valid, in_ready}, 0);
    rd(5, v);
    check(v == 0, "R10 register clear", v, 0);
  endtask

  task automatic t_single;
    logic [31:0] v;
    lst[0] = 32'h11223344; lst[1] = mk_hdr(5, 4'hF, 0, 0);
    run(2, 2);
    rd(5, v);
    check(v == 32'h11223344, "R1 data written", v, 32'h11223344);
    check(ev_n == 1, "R8 event count", ev_n, 1);
    check(ev_id[0] == 5 && ev_dat[0] == 32'h11223344, "R8 event fields", ev_dat[0], 32'h11223344);
    check(!busy && !in_ready, "R7 stop at length", {busy, in_ready}, 0);
  endtask

  task automatic t_mask;
    logic [31:0] v, e;
    e = mix(32'h11223344, 32'hAABBCCDD, 4'b0101);
    lst[0] = 32'hAABBCCDD; lst[1] = mk_hdr(5, 4'b0101, 0, 0);
    run(2, 2);
    rd(5, v);
    check(v == e, "R5 byte mask merge", v, e);
    check(ev_dat[0] == e, "R8 event has merged value", ev_dat[0], e);
  endtask

  task automatic t_group;
    logic [31:0] v;
    lst[0] = 32'hA0; lst[1] = mk_hdr(10, 4'hF, 3, 1);
    lst[2] = 32'hB1; lst[3] = 32'hC2; lst[4] = 32'hD3;
    run(5, 5);
    for (int i = 0; i < 4; i++) begin
      rd(10 + i, v);
      check(v == lst[i == 0 ? 0 : i + 1], "R4 consecutive burst", v, lst[i == 0 ? 0 : i + 1]);
    end
    check(ev_n == 4 && ev_id[3] == 13, "R3 burst events", ev_n, 4);
  endtask

  task automatic t_repeat;
    logic [31:0] v, e;
    e = mix(mix(mix(0, 32'h01020304, 4'b0011), 32'h05060708, 4'b0011), 32'h090A0B0C, 4'b0011);
    lst[0] = 32'h01020304; lst[1] = mk_hdr(20, 4'b0011, 2, 0);
    lst[2] = 32'h05060708; lst[3] = 32'h090A0B0C;
    run(4, 4);
    rd(20, v);
    check(v == e, "R3 repeated address masked", v, e);
    rd(21, v);
    check(v == 0, "R4 neighbour untouched", v, 0);
    check(ev_n == 3 && ev_id[1] == 20 && ev_id[2] == 20, "R4 repeat event ids", ev_id[2], 20);
  endtask

  task automatic t_align;
    logic [31:0] v;
    lst[0] = 32'h300; lst[1] = mk_hdr(30, 4'hF, 1, 0); lst[2] = 32'h301;
    lst[3] = 32'hDEADBEEF; lst[4] = 32'h310; lst[5] = mk_hdr(31, 4'hF, 0, 0);
    run(6, 6);
    rd(30, v);
    check(v == 32'h301, "R2 first command", v, 32'h301);
    rd(31, v);
    check(v == 32'h310, "R2 filler skipped", v, 32'h310);
    check(ev_n == 3 && !err, "R2 event count", ev_n, 3);
  endtask

  task automatic t_range;
    logic [31:0] v;
    lst[0] = 32'h77; lst[1] = mk_hdr(1024, 4'hF, 0, 0);
    lst[2] = 32'h88; lst[3] = mk_hdr(1023, 4'hF, 1, 1); lst[4] = 32'h99;
    run(5, 5);
    check(err, "R6 error flag", err, 1);
    check(ev_n == 1 && ev_id[0] == 1023, "R6 only valid write event", ev_n, 1);
    rd(0, v);
    check(v == 0, "R6 no aliasing", v, 0);
    rd(1023, v);
    check(v == 32'h88, "R6 in-range write", v, 32'h88);
  endtask

  task automatic t_clear;
    lst[0] = 32'h1; lst[1] = mk_hdr(2, 4'hF, 0, 0);
    run(2, 2);
    check(!err, "R10 start clears error", err, 0);
  endtask

  task automatic t_trunc;
    logic [31:0] v;
    lst[0] = 32'h400; lst[1] = mk_hdr(40, 4'hF, 2, 1); lst[2] = 32'h401; lst[3] = 32'h402;
    run(4, 3);
    check(err, "R9 truncated burst flag", err, 1);
    rd(41, v);
    check(v == 32'h401, "R9 earlier writes kept", v, 32'h401);
    rd(42, v);
    check(v == 0, "R9 rest dropped", v, 0);
    check(!busy && !in_ready, "R7 idle after truncation", {busy, in_ready}, 0);
    lst[0] = 32'h555;
    run(1, 1);
    check(err && ev_n == 0, "R9 lone data word", {err, 8'(ev_n)}, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_single();
        t_mask();
        t_group();
        t_repeat();
        t_align();
        t_range();
        t_clear();
        t_trunc();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule